// File: doc/BRIEF.md
# Microsecond System Timer with Match Channels

This block keeps a free-running 64-bit time base that steps by one each time the `tick_en` input pulses, which a clock divider elsewhere in the chip provides once per microsecond. Four compare channels watch the low 32 bits of that count. When the count steps onto the value held in a channel's compare register, the channel's match flag is set. The flag stays set until software clears it, and it drives that channel's own interrupt line.

Software uses a plain 32-bit register bus: a write strobe, a read strobe, a byte offset and data. To schedule an event, software reads the low count word, adds a delay and writes the sum to a compare register. Because the match uses only 32 bits, a sum that wraps past zero still fires once the low word wraps. A flag is cleared by writing a one to its bit in the status register.

Top module: `usec_match_timer`

## Requirements
- R1: After a cycle with `rst_n` low, the count equals the `CNT_INIT` parameter (default zero). All compare registers and match flags are zero, `irq` is all low and `bus_rdata` is zero.
- R2: The 64-bit count rises by exactly one on each clock edge where `tick_en` is high and holds otherwise. A carry out of the low 32 bits increments the high word.
- R3: At a clock edge where `bus_rd` is high, `bus_rdata` takes the value the addressed register held before that edge, and it keeps that value while `bus_rd` is low. The map is: 0x00 status (match flag n in bit n, upper bits zero), 0x04 count low word, 0x08 count high word, 0x0C/0x10/0x14/0x18 compare 0 to 3. Any other offset reads zero.
- R4: A write to 0x0C + 4n stores all 32 data bits in compare register n and changes no other compare register.
- R5: Match flag n is set at a clock edge where `tick_en` is high and the incremented low count word equals compare n. This includes a match reached after the low word wraps through zero. Writing a compare value equal to the current low word does not set the flag at once.
- R6: A set match flag stays set until it is cleared, and `irq[n]` always equals match flag n.
- R7: Writing to 0x00 clears each flag whose data bit [3:0] is one. Flags whose bit is zero are unchanged, and bits [31:4] are ignored.
- R8: If a match for channel n and a clear of flag n happen at the same edge, the flag ends up set.
- R9: Writes to 0x04, 0x08 or an unmapped offset change neither the count, the compare registers nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse per microsecond; advances the count |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 4 | Level interrupt per channel, high while its flag is set |

## Verification
The hardest case to reach from the ports is the low-word wrap, together with the carry into the high word. Starting from zero it would take over four billion ticks. The bench therefore builds the timer with `CNT_INIT` set 256 ticks below the wrap, so that compare values scheduled past zero, and the carry, are reached within a few hundred cycles. The match-and-clear collision is produced by stopping ticks, reading the count, writing a compare one step ahead, and then issuing the clear in the same cycle as a single tick. A behavioural model checks `irq` and `bus_rdata` on every clock while random ticks, clears and compare writes run.

// File: rtl/umt_pkg.sv
// Package: constants shared by the microsecond match timer.
// Assumes byte offsets on a 32-bit register bus; channel n's compare
// register sits at CMP_BASE + 4*n.
package umt_pkg;
    localparam int unsigned HALF_W   = 32;   // width of one count word and of a compare register
    localparam int unsigned NUM_CH   = 4;    // number of compare channels
    localparam int unsigned ADDR_W   = 5;    // byte offset width
    localparam int unsigned OFS_STAT = 0;    // match flags / write-one-to-clear
    localparam int unsigned OFS_LO   = 4;    // count bits [31:0]
    localparam int unsigned OFS_HI   = 8;    // count bits [63:32]
    localparam int unsigned CMP_BASE = 12;   // first compare register
endpackage

// File: rtl/umt_counter.sv
// Module: umt_counter
// A 64-bit free-running count that steps by one on each cycle with
// tick_en high. It also presents the low word as it will be after the next
// step, so that the channels can detect a match on the step itself.
// Assumes tick_en is a single-cycle enable in the clk domain.
module umt_counter #(
    parameter int unsigned HALF_W = 32,
    parameter logic [2*HALF_W-1:0] INIT = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    output logic [2*HALF_W-1:0] count,
    output logic [HALF_W-1:0]   next_lo
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    // Purpose: form the low word one step ahead for the match compare.
    always_comb begin
        next_lo = count[HALF_W-1:0] + HALF_W'(1);
    end

    // Purpose: advance the count on each tick; load INIT in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= INIT;
        end else if (tick_en) begin
            count <= count + FULL_W'(1);
        end
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && tick_en) |=> (count == $past(count) + FULL_W'(1)));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tick_en) |=> $stable(count));
endmodule

// File: rtl/umt_channel.sv
// Module: umt_channel
// One compare channel. It holds a compare word and a sticky match flag.
// The flag sets when the count steps onto the compare word and clears on a
// write-one-to-clear. A set in the same cycle as a clear wins.
// Assumes next_lo is the low count word after the step flagged by adv.
module umt_channel #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] next_lo,
    input  logic         cmp_we,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] cmp,
    output logic         flag
);
    logic hit;

    // Purpose: detect the step that lands on the compare word.
    always_comb begin
        hit = adv && (next_lo == cmp);
    end

    // Purpose: hold the compare word written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (cmp_we) begin
            cmp <= wdata;
        end
    end

    // Purpose: sticky match flag; a set overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cmp_we) |=> $stable(cmp));
    assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && adv && next_lo == cmp) |=> flag);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && flag && !clr) |=> flag);
    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr && !(adv && next_lo == cmp)) |=> !flag);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr && adv && next_lo == cmp) |=> flag);
endmodule

// File: rtl/umt_regs.sv
// Module: umt_regs
// Register decode and read mux. It turns bus writes into per-channel
// compare strobes and clear bits, and registers read data on bus_rd.
// Assumes exact byte offsets; misaligned or unlisted offsets are unmapped.
module umt_regs
    import umt_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [AW-1:0]       bus_addr,
    input  logic [W-1:0]        bus_wdata,
    input  logic [2*W-1:0]      count,
    input  logic [N-1:0][W-1:0] cmp,
    input  logic [N-1:0]        flags,
    output logic [N-1:0]        cmp_we,
    output logic [N-1:0]        clr,
    output logic [W-1:0]        bus_rdata
);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_LO   = AW'(OFS_LO);
    localparam logic [AW-1:0] A_HI   = AW'(OFS_HI);

    logic [W-1:0] rd_mux;

    // Purpose: write-one-to-clear bits for the status register.
    always_comb begin
        clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata[N-1:0] : '0;
    end

    // Purpose: one compare-write strobe per channel offset.
    for (genvar n = 0; n < N; n++) begin : g_cmp_dec
        assign cmp_we[n] = bus_wr && (bus_addr == AW'(CMP_BASE + 4 * n));
    end

    // Purpose: select the addressed register's current value.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_STAT) begin
            rd_mux = W'(flags);
        end else if (bus_addr == A_LO) begin
            rd_mux = count[W-1:0];
        end else if (bus_addr == A_HI) begin
            rd_mux = count[2*W-1:W];
        end
        for (int n = 0; n < N; n++) begin
            if (bus_addr == AW'(CMP_BASE + 4 * n)) begin
                rd_mux = cmp[n];
            end
        end
    end

    // Purpose: capture read data on a read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !bus_rd) |=> $stable(bus_rdata));
    assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_LO || bus_addr == A_HI)) |-> (cmp_we == '0 && clr == '0));
endmodule

// File: rtl/usec_match_timer.sv
// Module: usec_match_timer (top)
// A free-running 64-bit microsecond count with N compare channels on the
// low word. Each channel has a sticky flag and a level interrupt line.
// Assumes tick_en pulses once per microsecond in the clk domain.
module usec_match_timer
    import umt_pkg::*;
#(
    parameter int unsigned NUM_CH_P = NUM_CH,
    parameter int unsigned DATA_W   = HALF_W,
    parameter int unsigned ADDR_W_P = ADDR_W,
    parameter logic [2*DATA_W-1:0] CNT_INIT = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W_P-1:0] bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_CH_P-1:0] irq
);
    logic [2*DATA_W-1:0]             count;
    logic [DATA_W-1:0]               next_lo;
    logic [NUM_CH_P-1:0][DATA_W-1:0] cmp;
    logic [NUM_CH_P-1:0]             flags;
    logic [NUM_CH_P-1:0]             cmp_we;
    logic [NUM_CH_P-1:0]             clr;

    umt_counter #(.HALF_W(DATA_W), .INIT(CNT_INIT)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (count),
        .next_lo (next_lo)
    );

    for (genvar n = 0; n < NUM_CH_P; n++) begin : g_ch
        umt_channel #(.W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (tick_en),
            .next_lo (next_lo),
            .cmp_we  (cmp_we[n]),
            .wdata   (bus_wdata),
            .clr     (clr[n]),
            .cmp     (cmp[n]),
            .flag    (flags[n])
        );
    end

    umt_regs #(.N(NUM_CH_P), .W(DATA_W), .AW(ADDR_W_P)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count),
        .cmp       (cmp),
        .flags     (flags),
        .cmp_we    (cmp_we),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    // Purpose: each interrupt line follows its channel's flag level.
    always_comb begin
        irq = flags;
    end
endmodule

// File: tb/tb_usec_match_timer.sv
`timescale 1ns/1ps
module tb_usec_match_timer;
    localparam logic [63:0] TB_INIT = 64'h0000_0000_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    usec_match_timer #(.CNT_INIT(TB_INIT)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_err = 0;
    int tick_mode = 0;           // 0 off, 1 every cycle, 2 pseudo-random
    logic [15:0] lfsr = 16'hACE1;
    bit done = 1'b0;

    // Behavioural reference state
    logic [63:0] mcnt;
    logic [31:0] mcmp [4];
    logic [3:0]  mflg;
    logic [31:0] mrd;
    logic [63:0] m_nc;
    logic [3:0]  m_nf;
    bit          started = 1'b0;

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a)
            5'h00: return {28'b0, mflg};
            5'h04: return mcnt[31:0];
            5'h08: return mcnt[63:32];
            5'h0C: return mcmp[0];
            5'h10: return mcmp[1];
            5'h14: return mcmp[2];
            5'h18: return mcmp[3];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            mcnt = TB_INIT; mflg = '0; mrd = '0;
            for (int n = 0; n < 4; n++) mcmp[n] = '0;
        end else begin
            if (bus_rd) mrd = model_read(bus_addr);
            m_nf = mflg;
            if (bus_wr && bus_addr == 5'h00) m_nf = m_nf & ~bus_wdata[3:0];
            m_nc = mcnt + (tick_en ? 64'd1 : 64'd0);
            if (tick_en)
                for (int n = 0; n < 4; n++)
                    if (m_nc[31:0] == mcmp[n]) m_nf[n] = 1'b1;
            if (bus_wr)
                for (int n = 0; n < 4; n++)
                    if (bus_addr == 5'(12 + 4 * n)) mcmp[n] = bus_wdata;
            mflg = m_nf;
            mcnt = m_nc;
        end
    end

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check(64'(irq), 64'(mflg), "R6 irq vs model");
            check(64'(bus_rdata), 64'(mrd), "R3 rdata vs model");
        end
    end

    function automatic logic pick_tick();
        if (tick_mode == 1) return 1'b1;
        if (tick_mode == 2) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            return lfsr[0];
        end
        return 1'b0;
    endfunction

    task automatic step(input logic wr, input logic rd, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        tick_en = pick_tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'h0, 32'h0);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, 1'b1, a, 32'h0);
        step(1'b0, 1'b0, 5'h0, 32'h0);
        check(64'(bus_rdata), 64'(exp), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        check(64'(irq), 64'h0, "R1 irq after reset");
        check(64'(bus_rdata), 64'h0, "R1 rdata after reset");
        rd_chk(5'h04, 32'hFFFF_FF00, "R1 count low at init");
        rd_chk(5'h08, 32'h0, "R1 count high at init");
        rd_chk(5'h00, 32'h0, "R1 flags clear");
        rd_chk(5'h10, 32'h0, "R1 compare1 zero");
        // R2: five ticks, then hold
        tick_mode = 1; idle(5); tick_mode = 0;
        rd_chk(5'h04, 32'hFFFF_FF05, "R2 five ticks");
        idle(3);
        rd_chk(5'h04, 32'hFFFF_FF05, "R2 hold without tick");
        // R4: compare writes
        wr(5'h0C, 32'hFFFF_FF0A);
        wr(5'h10, 32'h0000_0020);
        wr(5'h14, 32'h0000_0050);
        wr(5'h18, 32'hFFFF_FFFF);
        rd_chk(5'h0C, 32'hFFFF_FF0A, "R4 compare0 readback");
        rd_chk(5'h18, 32'hFFFF_FFFF, "R4 compare3 readback");
        rd_chk(5'h1C, 32'h0, "R3 unmapped reads zero");
        // R9: writes to counter and unmapped offsets ignored
        wr(5'h04, 32'h1234_5678);
        wr(5'h08, 32'h0000_DEAD);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd_chk(5'h04, 32'hFFFF_FF05, "R9 low word unchanged");
        rd_chk(5'h08, 32'h0, "R9 high word unchanged");
        rd_chk(5'h10, 32'h0000_0020, "R9 compare1 unchanged");
        rd_chk(5'h00, 32'h0, "R9 flags unchanged");
        // R5: equal compare written does not fire at once
        wr(5'h14, 32'hFFFF_FF05);
        idle(2);
        check(64'(irq), 64'h0, "R5 no match on compare write");
        // R5: four ticks, no match; fifth lands on FF0A
        tick_mode = 1; idle(4); tick_mode = 0; idle(1);
        check(64'(irq), 64'h0, "R5 no match before compare");
        tick_mode = 1; idle(1); tick_mode = 0; idle(1);
        check(64'(irq), 64'h1, "R5 channel0 matches");
        // R6: sticky
        idle(10);
        check(64'(irq), 64'h1, "R6 flag sticky");
        rd_chk(5'h00, 32'h1, "R6 status shows flag");
        // R7: zero bits and upper bits have no effect; one bit clears
        wr(5'h00, 32'hFFFF_FFFE); idle(1);
        rd_chk(5'h00, 32'h1, "R7 zero bit keeps flag");
        wr(5'h00, 32'h0); idle(1);
        check(64'(irq), 64'h1, "R7 write zero no effect");
        wr(5'h00, 32'h1); idle(1);
        check(64'(irq), 64'h0, "R7 write one clears");
        // R8: compare one step ahead, clear in the same cycle as the tick
        wr(5'h14, 32'hFFFF_FF0B);
        wr(5'h00, 32'h4);
        tick_mode = 1; wr(5'h00, 32'h4); tick_mode = 0;
        idle(1);
        check(64'(irq), 64'h4, "R8 set wins over clear");
        rd_chk(5'h00, 32'h4, "R8 status after collision");
        // R5/R2: wrap and carry with random ticks
        wr(5'h00, 32'hF);
        tick_mode = 2;
        for (int i = 0; i < 3000 && mcnt < 64'h1_0000_0030; i++) idle(1);
        tick_mode = 0; idle(1);
        check(64'(irq), 64'hA, "R5 matches across wrap");
        rd_chk(5'h08, 32'h1, "R2 carry into high word");
        rd_chk(5'h04, mcnt[31:0], "R2 low word after wrap");
        // Mixed random traffic, checked each cycle by the model
        tick_mode = 2;
        for (int i = 0; i < 400; i++) begin
            case (lfsr[3:1])
                3'd0: wr(5'h00, {28'h0, lfsr[7:4]});
                3'd1: wr(5'(12 + 4 * int'(lfsr[9:8])), mcnt[31:0] + 32'(lfsr[6:4]));
                3'd2: step(1'b0, 1'b1, {lfsr[12:10], 2'b00}, 32'h0);
                3'd3: wr(5'h04, {16'h0, lfsr});
                default: idle(1);
            endcase
        end
        tick_mode = 0; idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule